// File: doc/BRIEF.md
# Tree Carry Look-Ahead Adder

This block adds two N-bit unsigned operands and a carry-in, and returns the N-bit sum together with the carry-out. It has no clock and no state. Every bit position forms its own propagate and generate terms. A balanced binary tree of combining nodes then folds those terms into group terms, level by level, until one root group covers the whole word. The carry-in enters at the root, and each node passes a carry into the upper half of its span, so every bit gets its incoming carry after a number of node delays that grows with log2 of the width.

The block is meant to sit in a datapath where a ripple chain would be too slow. The width must be a power of two. The default is 8, which gives a three-level tree. Wider words such as 32 use the same structure with more levels.

Top module: `tree_cla_adder`

## Requirements
- R1: `sum` equals `(a + b + cin) mod 2^N` for every combination of operands and carry-in.
- R2: `cout` equals bit N of the (N+1)-bit value `a + b + cin`.
- R3: When every bit propagates (`a == ~b`), `cout` equals `cin`. `sum` is all ones when `cin` is 0 and all zeros when `cin` is 1.
- R4: When every bit kills (`a == 0` and `b == 0`), `sum` bit 0 equals `cin`, every other `sum` bit is 0, and `cout` is 0.
- R5: A carry generated at bit 0 (`a[0] = b[0] = 1`) with every higher bit propagating travels the full word. `sum` bit 0 equals `cin`, every higher bit is 0, and `cout` is 1.
- R6: N must be a power of two and at least 2, or elaboration stops. With N = 32, R1 and R2 still hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | First operand, unsigned |
| b | input | N | Second operand, unsigned |
| cin | input | 1 | Carry into bit 0 |
| sum | output | N | Low N bits of a + b + cin |
| cout | output | 1 | Carry out of the most significant bit |

## Verification
The block has no state, so a wrong combining node or a wrong carry split shows up at once, on the same set of inputs, as a sum bit or a carry-out that differs from the arithmetic result. A fault in a node's generate path corrupts only the bits above that node's lower half, and only for operands where that half generates or propagates. For this reason the 8-bit configuration is swept over every operand pair and carry-in. The long all-propagate, all-kill and full-length-carry patterns are also applied on their own. The 32-bit configuration is covered with random vectors and with the same corner patterns.

// File: rtl/tcla_pkg.sv
// Package: tcla_pkg
// Shared types and combining functions for the tree carry look-ahead adder.
// Assumes a group is described by a propagate bit and a generate bit.
package tcla_pkg;

    // Propagate/generate pair describing a bit or a group of bits
    typedef struct packed {
        logic p;
        logic g;
    } pg_t;

    // Fold a lower group and the group just above it into one group
    function automatic pg_t pg_combine(input pg_t lo, input pg_t hi);
        pg_t res;
        res.p = lo.p & hi.p;
        res.g = hi.g | (lo.g & hi.p);
        return res;
    endfunction

    // Carry leaving a group, given the carry that entered it
    function automatic logic carry_through(input pg_t grp, input logic c_in);
        return grp.g | (grp.p & c_in);
    endfunction

endpackage

// File: rtl/tcla_bit_cell.sv
// Module: tcla_bit_cell
// Forms the per-bit propagate and generate terms from one bit of each operand.
// Assumes the operands are unsigned and the bits line up.
module tcla_bit_cell (
    input  logic bit_a,
    input  logic bit_b,
    output logic bit_p,
    output logic bit_g
);

    // Propagate when exactly one operand bit is set, generate when both are
    always_comb begin
        bit_p = bit_a ^ bit_b;
        bit_g = bit_a & bit_b;
    end

    // A single bit never both propagates and generates
    always_comb begin
        if (!$isunknown({bit_p, bit_g}))
            AST_BIT_PG_EXCL: assert (!(bit_p && bit_g)); // R3
    end

endmodule

// File: rtl/tcla_merge_node.sv
// Module: tcla_merge_node
// One node of the tree. Going up, it folds the terms of its lower and upper
// child groups into one group. Going down, it splits the carry entering its
// span into a carry for each child. Assumes the lower child covers the less
// significant half of the span.
module tcla_merge_node
    import tcla_pkg::*;
(
    input  logic lo_p,
    input  logic lo_g,
    input  logic hi_p,
    input  logic hi_g,
    input  logic span_cin,
    output logic grp_p,
    output logic grp_g,
    output logic lo_cin,
    output logic hi_cin
);

    pg_t lo_pg;
    pg_t hi_pg;
    pg_t grp_pg;

    // Up-sweep: fold the children into a group term
    always_comb begin
        lo_pg  = '{p: lo_p, g: lo_g};
        hi_pg  = '{p: hi_p, g: hi_g};
        grp_pg = pg_combine(lo_pg, hi_pg);
        grp_p  = grp_pg.p;
        grp_g  = grp_pg.g;
    end

    // Down-sweep: the lower half takes the span carry, the upper half takes the carry out of the lower half
    always_comb begin
        lo_cin = span_cin;
        hi_cin = carry_through(lo_pg, span_cin);
    end

    // Group terms and the carry split must agree with the child terms
    always_comb begin
        if (!$isunknown({lo_p, lo_g, hi_p, hi_g, span_cin, grp_p, grp_g, hi_cin})) begin
            AST_GRP_PG_EXCL: assert (!(grp_p && grp_g)); // R3
            AST_HI_CARRY_PASS: assert (!lo_p || (hi_cin == span_cin)); // R3
            AST_HI_CARRY_KILL: assert (lo_p || lo_g || !hi_cin); // R4
            AST_HI_CARRY_GEN: assert (!lo_g || hi_cin); // R5
        end
    end

endmodule

// File: rtl/tcla_sum_stage.sv
// Module: tcla_sum_stage
// Forms every sum bit from that bit's propagate term and incoming carry.
// Assumes each carry has already come down the tree to its leaf.
module tcla_sum_stage #(
    parameter int N = 8
) (
    input  logic [N-1:0] leaf_p,
    input  logic [N-1:0] leaf_c,
    output logic [N-1:0] sum_out
);

    // Each sum bit is the propagate term flipped by its incoming carry
    always_comb begin
        sum_out = leaf_p ^ leaf_c;
    end

endmodule

// File: rtl/tree_cla_adder.sv
// Module: tree_cla_adder
// N-bit adder with a logarithmic-depth carry tree. Nodes are stored in heap
// order: node 1 is the root, node j has children 2j (lower) and 2j+1 (upper),
// and leaf N+i is bit i. Propagate/generate terms move up the tree and carries
// move back down. Assumes N is a power of two of at least 2.
module tree_cla_adder #(
    parameter int N = 8
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         cin,
    output logic [N-1:0] sum,
    output logic         cout
);

    localparam int HEAP_TOP = 2 * N - 1;

    // Width check at elaboration
    if (N < 2 || (N & (N - 1)) != 0) begin : g_bad_width
        $error("tree_cla_adder: N must be a power of two and at least 2");
    end

    logic [HEAP_TOP:1] node_p;
    logic [HEAP_TOP:1] node_g;
    logic [HEAP_TOP:1] node_c;

    // Leaves: one bit cell per bit position
    for (genvar i = 0; i < N; i++) begin : g_leaf
        tcla_bit_cell u_bit (
            .bit_a (a[i]),
            .bit_b (b[i]),
            .bit_p (node_p[N + i]),
            .bit_g (node_g[N + i])
        );
    end

    // Internal nodes: combine children going up, split carries going down
    for (genvar j = 1; j < N; j++) begin : g_node
        tcla_merge_node u_node (
            .lo_p     (node_p[2 * j]),
            .lo_g     (node_g[2 * j]),
            .hi_p     (node_p[2 * j + 1]),
            .hi_g     (node_g[2 * j + 1]),
            .span_cin (node_c[j]),
            .grp_p    (node_p[j]),
            .grp_g    (node_g[j]),
            .lo_cin   (node_c[2 * j]),
            .hi_cin   (node_c[2 * j + 1])
        );
    end

    // The root span takes the external carry-in
    assign node_c[1] = cin;

    tcla_sum_stage #(.N(N)) u_sum (
        .leaf_p  (node_p[HEAP_TOP:N]),
        .leaf_c  (node_c[HEAP_TOP:N]),
        .sum_out (sum)
    );

    // Carry-out from the root group terms
    always_comb begin
        cout = node_g[1] | (node_p[1] & cin);
    end

    // Arithmetic cross-check of the outputs against the operands
    logic [N:0] arith_total;
    always_comb begin
        arith_total = {1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin};
        if (!$isunknown({a, b, cin, sum, cout})) begin
            AST_SUM_ARITH: assert (sum == arith_total[N-1:0]); // R1
            AST_COUT_ARITH: assert (cout == arith_total[N]); // R2
        end
    end

endmodule

// File: tb/test_tree_cla_adder.sv
// Bench for tree_cla_adder: every input combination of the 8-bit configuration,
// corner patterns, and random vectors for a 32-bit configuration.
module test_tree_cla_adder;

    localparam int CLK_PERIOD  = 10;
    localparam int N8          = 8;
    localparam int N32         = 32;
    localparam int CYCLE_LIMIT = 190000;
    localparam int RAND_COUNT  = 3000;

    logic clk = 1'b0;
    int   cycles = 0;
    int   tests = 0;
    int   fails = 0;
    bit   done = 1'b0;

    logic [N8-1:0]  a8, b8, sum8;
    logic           cin8, cout8;
    logic [N32-1:0] a32, b32, sum32;
    logic           cin32, cout32;

    tree_cla_adder #(.N(N8)) i_tree_cla_adder (
        .a(a8), .b(b8), .cin(cin8), .sum(sum8), .cout(cout8)
    );

    tree_cla_adder #(.N(N32)) i_tree_cla_adder_w32 (
        .a(a32), .b(b32), .cin(cin32), .sum(sum32), .cout(cout32)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Watchdog: a hung run is counted as a failure and still reports
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > CYCLE_LIMIT && !done) begin
            tests = tests + 1;
            fails = fails + 1;
            $display("FAIL R1 watchdog: actual=%0d cycles expected=<%0d", cycles, CYCLE_LIMIT);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check8(input logic [N8-1:0] ea, input logic [N8-1:0] eb,
                          input logic ec, input string req_sum, input string req_cout);
        logic [N8:0] exp_total;
        @(posedge clk);
        a8 = ea; b8 = eb; cin8 = ec;
        exp_total = {1'b0, ea} + {1'b0, eb} + {8'd0, ec};
        @(negedge clk);
        tests = tests + 2;
        if (sum8 !== exp_total[N8-1:0]) begin
            fails = fails + 1;
            $display("FAIL %s sum a=%h b=%h cin=%b: actual=%h expected=%h",
                     req_sum, ea, eb, ec, sum8, exp_total[N8-1:0]);
        end
        if (cout8 !== exp_total[N8]) begin
            fails = fails + 1;
            $display("FAIL %s cout a=%h b=%h cin=%b: actual=%b expected=%b",
                     req_cout, ea, eb, ec, cout8, exp_total[N8]);
        end
    endtask

    task automatic check32(input logic [N32-1:0] ea, input logic [N32-1:0] eb,
                           input logic ec, input string req);
        logic [N32:0] exp_total;
        @(posedge clk);
        a32 = ea; b32 = eb; cin32 = ec;
        exp_total = {1'b0, ea} + {1'b0, eb} + {32'd0, ec};
        @(negedge clk);
        tests = tests + 1;
        if ({cout32, sum32} !== exp_total) begin
            fails = fails + 1;
            $display("FAIL %s a=%h b=%h cin=%b: actual=%h expected=%h",
                     req, ea, eb, ec, {cout32, sum32}, exp_total);
        end
    endtask

    initial begin
        a8 = '0; b8 = '0; cin8 = 1'b0;
        a32 = '0; b32 = '0; cin32 = 1'b0;

        // R4: all-kill patterns, including the idle inputs
        check8(8'h00, 8'h00, 1'b0, "R4", "R4");
        check8(8'h00, 8'h00, 1'b1, "R4", "R4");
        // R3: all-propagate patterns
        check8(8'hA5, 8'h5A, 1'b0, "R3", "R3");
        check8(8'hA5, 8'h5A, 1'b1, "R3", "R3");
        check8(8'hFF, 8'h00, 1'b1, "R3", "R3");
        // R5: carry born at bit 0 crossing the whole word
        check8(8'h01, 8'hFF, 1'b0, "R5", "R5");
        check8(8'hFF, 8'h01, 1'b1, "R5", "R5");

        // R1, R2: every operand pair and carry-in of the 8-bit configuration
        for (int av = 0; av < 256; av++) begin
            for (int bv = 0; bv < 256; bv++) begin
                for (int cv = 0; cv < 2; cv++) begin
                    check8(av[7:0], bv[7:0], cv[0], "R1", "R2");
                end
            end
        end

        // R6: 32-bit configuration corner patterns and random vectors
        check32(32'h0000_0000, 32'h0000_0000, 1'b1, "R6");
        check32(32'hFFFF_FFFF, 32'h0000_0000, 1'b1, "R6");
        check32(32'h0000_0001, 32'hFFFF_FFFF, 1'b0, "R6");
        check32(32'h8000_0000, 32'h8000_0000, 1'b1, "R6");
        for (int k = 0; k < RAND_COUNT; k++) begin
            check32($urandom, $urandom, 1'($urandom), "R6");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule